// File: doc/BRIEF.md
# Reload-and-Compare PWM Timer

This block produces a pulse-width-modulated output from a free-running up-counter. The counter climbs from a programmable reload value to all-ones. When it wraps, it reloads that value and drives the output to its active level. When the count equals a programmable compare value, it drives the output back to its inactive level. The reload value sets the period and the compare value sets the active time. The counter can be written directly. Software starts a waveform by presetting the counter to all-ones minus one before setting the run bit, so the first active edge appears after two clocks.

A control write sets the run bit and the output polarity, and a status pair reports both back. Stopping is immediate: the counter and the output level freeze where they are. The reload and compare registers are not double-buffered. A new reload value is used at the next wrap, and a new compare value is used from the next clock, so one period can mix old and new settings.

Top module: `rcpwm_timer`

## Requirements
- R1: After synchronous reset the count, reload and compare registers are 0, the run and polarity bits are 0, and `pwm_out` is 0.
- R2: While running and neither at all-ones nor being written, the count increases by exactly one per clock. While stopped and not written, it holds.
- R3: While running, a clock at which the count is all-ones loads the reload value into the counter and makes the output level active on that same edge. With the counter preset to all-ones minus one, the output is active two clocks after the run bit is set.
- R4: While running, a clock at which the count equals the compare value (and is not all-ones) makes the output level inactive.
- R5: When the count is all-ones and the compare value is also all-ones, the wrap wins and the level becomes active.
- R6: With reload L and compare M where L <= M < all-ones, each period lasts (all-ones - L + 1) clocks, the active phase lasts (M - L + 1) clocks and the inactive phase lasts (all-ones - M) clocks. This includes the 2-clock minimum period with M = L.
- R7: A counter write (`count_we`) loads `wr_data` into the counter on that edge, takes priority over counting, and suppresses the wrap and match events for that clock.
- R8: Clearing the run bit halts the counter at once. The output keeps its level until the timer runs again.
- R9: `pwm_out` equals the internal level when the polarity bit is 0. It equals the inverted level when the polarity bit is 1, so with polarity 1 the active level is low.
- R10: A control write changes the polarity bit only if the timer was stopped before that write. A polarity change while running is ignored.
- R11: Reload and compare writes are not buffered. A new reload value is used at the next wrap, and a new compare value is used from the next clock, even in the middle of a period.
- R12: `stat_running` reports the run bit and `stat_pol` reports the polarity bit. Both are updated on the edge of the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | CNT_W | Data for reload, compare and counter writes |
| load_we | input | 1 | Write `wr_data` to the reload register |
| match_we | input | 1 | Write `wr_data` to the compare register |
| count_we | input | 1 | Write `wr_data` to the counter |
| ctrl_we | input | 1 | Write the run and polarity bits |
| ctrl_run | input | 1 | Run bit value for a control write |
| ctrl_pol | input | 1 | Polarity bit value for a control write (1 = active low) |
| pwm_out | output | 1 | PWM waveform |
| count_val | output | CNT_W | Current counter value |
| stat_running | output | 1 | Run bit status |
| stat_pol | output | 1 | Polarity bit status |

## Verification
Every cycle, the assertions check the following:
- the counter steps by one, reloads at all-ones and holds while stopped;
- counter writes are taken;
- the level goes active on a wrap and inactive on a match, with the wrap winning when both are due, and holds otherwise;
- the polarity bit stays frozen while running.

Only the bench's scenarios can show the waveform timing over whole periods:
- measured active and inactive lengths against the period formulas under both polarities, including the 2-clock minimum;
- the two-clock start-up after the preset;
- the one mixed period that follows a mid-period reload or compare update.

// File: rtl/rcpwm_pkg.sv
package rcpwm_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_WRAP  = 2'd1,
        EV_MATCH = 2'd2
    } pwm_event_e;

    typedef struct packed {
        logic run;
        logic pol;
    } ctrl_t;

    // Wrap has priority over match when both are due on one clock.
    function automatic pwm_event_e classify_event(
        input logic counting,
        input logic at_top,
        input logic at_match
    );
        if (!counting)
            return EV_NONE;
        else if (at_top)
            return EV_WRAP;
        else if (at_match)
            return EV_MATCH;
        else
            return EV_NONE;
    endfunction

endpackage

// File: rtl/rcpwm_regs.sv
module rcpwm_regs
    import rcpwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_we,
    input  logic             match_we,
    input  logic             ctrl_we,
    input  logic             ctrl_run,
    input  logic             ctrl_pol,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] match_q,
    output ctrl_t            ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q  <= '0;
            match_q <= '0;
            ctrl_q  <= '{run: 1'b0, pol: 1'b0};
        end else begin
            if (load_we)
                load_q <= wr_data;
            if (match_we)
                match_q <= wr_data;
            if (ctrl_we) begin
                ctrl_q.run <= ctrl_run;
                if (!ctrl_q.run)
                    ctrl_q.pol <= ctrl_pol;
            end
        end
    end

    a_r10_pol_frozen_running: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.run |=> $stable(ctrl_q.pol));

    a_r12_run_follows_write: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> ctrl_q.run == $past(ctrl_run));

endmodule

// File: rtl/rcpwm_counter.sv
module rcpwm_counter
    import rcpwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             count_we,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] load_q,
    input  logic [CNT_W-1:0] match_q,
    output logic [CNT_W-1:0] cnt_q,
    output pwm_event_e       ev
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic counting;
    logic at_top;
    logic at_match;

    assign counting = run && !count_we;
    assign at_top   = (cnt_q == CNT_TOP);
    assign at_match = (cnt_q == match_q);

    always_comb begin
        ev = classify_event(counting, at_top, at_match);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (count_we)
            cnt_q <= wr_data;
        else if (run)
            cnt_q <= at_top ? load_q : cnt_q + 1'b1;
    end

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (run && !count_we && cnt_q != CNT_TOP) |=> cnt_q == $past(cnt_q) + 1'b1);

    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !count_we) |=> $stable(cnt_q));

    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (run && !count_we && cnt_q == CNT_TOP) |=> cnt_q == $past(load_q));

    a_r5_wrap_wins: assert property (@(posedge clk) disable iff (rst)
        (run && !count_we && cnt_q == CNT_TOP && match_q == CNT_TOP) |-> ev == EV_WRAP);

    a_r7_count_write: assert property (@(posedge clk) disable iff (rst)
        count_we |=> cnt_q == $past(wr_data));

endmodule

// File: rtl/rcpwm_wave.sv
module rcpwm_wave
    import rcpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwm_event_e ev,
    input  logic       pol,
    output logic       level_q,
    output logic       pwm_out
);

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= 1'b0;
        else begin
            case (ev)
                EV_WRAP:  level_q <= 1'b1;
                EV_MATCH: level_q <= 1'b0;
                default:  level_q <= level_q;
            endcase
        end
    end

    assign pwm_out = level_q ^ pol;

    a_r3_goes_active: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_WRAP) |=> level_q);

    a_r4_goes_inactive: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_MATCH) |=> !level_q);

    a_r8_level_holds: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_NONE) |=> $stable(level_q));

endmodule

// File: rtl/rcpwm_timer.sv
module rcpwm_timer
    import rcpwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_we,
    input  logic             match_we,
    input  logic             count_we,
    input  logic             ctrl_we,
    input  logic             ctrl_run,
    input  logic             ctrl_pol,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count_val,
    output logic             stat_running,
    output logic             stat_pol
);

    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] match_q;
    ctrl_t            ctrl_q;
    pwm_event_e       ev;
    logic             level_q;

    rcpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (wr_data),
        .load_we  (load_we),
        .match_we (match_we),
        .ctrl_we  (ctrl_we),
        .ctrl_run (ctrl_run),
        .ctrl_pol (ctrl_pol),
        .load_q   (load_q),
        .match_q  (match_q),
        .ctrl_q   (ctrl_q)
    );

    rcpwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .count_we (count_we),
        .wr_data  (wr_data),
        .load_q   (load_q),
        .match_q  (match_q),
        .cnt_q    (count_val),
        .ev       (ev)
    );

    rcpwm_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .pol     (ctrl_q.pol),
        .level_q (level_q),
        .pwm_out (pwm_out)
    );

    assign stat_running = ctrl_q.run;
    assign stat_pol     = ctrl_q.pol;

    // R8: the output can only move while the timer runs or the polarity changes
    a_r8_out_frozen_stopped: assert property (@(posedge clk) disable iff (rst)
        (!stat_running && !ctrl_we) |=> $stable(pwm_out));

endmodule

// File: tb/test_rcpwm_timer.sv
module test_rcpwm_timer;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam logic [W-1:0] TOP = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic         load_we = 1'b0, match_we = 1'b0, count_we = 1'b0;
    logic         ctrl_we = 1'b0, ctrl_run = 1'b0, ctrl_pol = 1'b0;
    logic         pwm_out, stat_running, stat_pol;
    logic [W-1:0] count_val;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcpwm_timer #(.CNT_W(W)) i_rcpwm_timer (
        .clk(clk), .rst(rst), .wr_data(wr_data),
        .load_we(load_we), .match_we(match_we), .count_we(count_we),
        .ctrl_we(ctrl_we), .ctrl_run(ctrl_run), .ctrl_pol(ctrl_pol),
        .pwm_out(pwm_out), .count_val(count_val),
        .stat_running(stat_running), .stat_pol(stat_pol)
    );

    // Behavioural reference state
    logic [W-1:0] m_cnt, m_load, m_match;
    bit m_run, m_pol, m_lvl;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_load = '0; m_match = '0;
            m_run = 0; m_pol = 0; m_lvl = 0;
        end else begin
            bit old_run;
            logic [W-1:0] old_load;
            old_run = m_run;
            old_load = m_load;
            if (count_we) m_cnt = wr_data;
            else if (old_run) begin
                if (m_cnt == TOP) begin
                    m_lvl = 1;
                    m_cnt = old_load;
                end else begin
                    if (m_cnt == m_match) m_lvl = 0;
                    m_cnt = m_cnt + 1;
                end
            end
            if (load_we) m_load = wr_data;
            if (match_we) m_match = wr_data;
            if (ctrl_we) begin
                m_run = ctrl_run;
                if (!old_run) m_pol = ctrl_pol;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(count_val === m_cnt, "R2", "count", count_val, m_cnt);
            check(pwm_out === (m_lvl ^ m_pol), "R9", "pwm_out", pwm_out, m_lvl ^ m_pol);
            check(stat_running === m_run, "R12", "running", stat_running, m_run);
            check(stat_pol === m_pol, "R12", "polarity", stat_pol, m_pol);
        end
    end

    task automatic wr(input int which, input logic [W-1:0] v);
        @(negedge clk);
        wr_data = v;
        case (which)
            0: load_we = 1;
            1: match_we = 1;
            default: count_we = 1;
        endcase
        @(negedge clk);
        load_we = 0; match_we = 0; count_we = 0;
    endtask

    task automatic ctl(input bit run, input bit pol);
        @(negedge clk);
        ctrl_we = 1; ctrl_run = run; ctrl_pol = pol;
        @(negedge clk);
        ctrl_we = 0;
    endtask

    task automatic measure(input bit inv, output int act_t, output int inact_t);
        int g = 0;
        act_t = 0; inact_t = 0;
        while (((pwm_out ^ inv) !== 1'b0) && g < 200) begin @(negedge clk); g++; end
        while (((pwm_out ^ inv) !== 1'b1) && g < 400) begin @(negedge clk); g++; end
        while (((pwm_out ^ inv) === 1'b1) && g < 600) begin act_t++; @(negedge clk); g++; end
        while (((pwm_out ^ inv) === 1'b0) && g < 800) begin inact_t++; @(negedge clk); g++; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int a, b, bad;
        logic [W-1:0] hold_c;
        bit hold_o;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(count_val == 0 && pwm_out == 0 && !stat_running && !stat_pol,
              "R1", "reset state", {count_val, pwm_out, stat_running, stat_pol}, 0);

        // R3/R6: period 10, active 4, normal polarity
        wr(0, TOP - 9);
        wr(1, TOP - 6);
        wr(2, TOP - 1);
        ctl(1, 0);
        @(negedge clk);
        check(pwm_out == 0 && count_val == TOP, "R3", "before first edge", pwm_out, 0);
        @(negedge clk);
        check(pwm_out == 1 && count_val == TOP - 9, "R3", "first active edge", count_val, TOP - 9);
        for (int k = 0; k < 3; k++) begin
            measure(0, a, b);
            check(a == 4, "R6", "active time", a, 4);
            check(b == 6, "R6", "inactive time", b, 6);
        end

        // R8 stop holds counter and output
        ctl(0, 0);
        hold_c = count_val;
        hold_o = pwm_out;
        repeat (5) @(negedge clk);
        check(count_val == hold_c, "R8", "count held", count_val, hold_c);
        check(pwm_out == hold_o, "R8", "output held", pwm_out, hold_o);
        check(!stat_running, "R12", "running cleared", stat_running, 0);

        // R9 inverted polarity, restart with preset
        ctl(0, 1);
        check(stat_pol == 1, "R12", "polarity set", stat_pol, 1);
        check(pwm_out == !hold_o, "R9", "inverted output", pwm_out, !hold_o);
        wr(2, TOP - 1);
        check(count_val == TOP - 1, "R7", "count write", count_val, TOP - 1);
        ctl(1, 1);
        for (int k = 0; k < 2; k++) begin
            measure(1, a, b);
            check(a == 4, "R9", "active-low time", a, 4);
            check(b == 6, "R9", "inactive-high time", b, 6);
        end

        // R10 polarity write ignored while running
        ctl(1, 0);
        check(stat_pol == 1, "R10", "polarity unchanged", stat_pol, 1);
        measure(1, a, b);
        check(a == 4 && b == 6, "R10", "waveform unchanged", a, 4);

        // R11 unbuffered load/match: new period 6 active 2
        wr(0, TOP - 5);
        wr(1, TOP - 4);
        measure(1, a, b);
        measure(1, a, b);
        check(a == 2, "R11", "new active time", a, 2);
        check(b == 4, "R11", "new inactive time", b, 4);
        // compare value takes effect on the next clock
        bad = 0;
        while (!((pwm_out ^ stat_pol) == 1 && count_val == TOP - 5) && bad < 50) begin
            @(negedge clk); bad++;
        end
        wr_data = TOP - 4; match_we = 1;
        @(negedge clk);
        match_we = 0;
        wr_data = TOP - 5;
        match_we = 1;
        check((pwm_out ^ stat_pol) == 1, "R11", "still active", pwm_out, !stat_pol);
        @(negedge clk);
        match_we = 0;
        @(negedge clk);
        check((pwm_out ^ stat_pol) == 0, "R11", "early match", pwm_out, stat_pol);

        // R5 wrap wins over match at all-ones
        ctl(0, 1);
        ctl(0, 0);
        wr(0, TOP - 3);
        wr(1, TOP);
        wr(2, TOP - 1);
        ctl(1, 0);
        repeat (2) @(negedge clk);
        bad = 0;
        for (int k = 0; k < 12; k++) begin
            if (pwm_out !== 1'b1) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R5", "output stays active", bad, 0);

        // R6 minimum period: 2 clocks, active 1
        ctl(0, 0);
        wr(0, TOP - 1);
        wr(1, TOP - 1);
        wr(2, TOP - 1);
        ctl(1, 0);
        for (int k = 0; k < 2; k++) begin
            measure(0, a, b);
            check(a == 1 && b == 1, "R6", "minimum period", {a[15:0], b[15:0]}, {16'd1, 16'd1});
        end

        // R4 match inside a longer period: load 0..., active 3
        ctl(0, 0);
        wr(0, TOP - 7);
        wr(1, TOP - 5);
        wr(2, TOP - 1);
        ctl(1, 0);
        measure(0, a, b);
        check(a == 3 && b == 5, "R4", "match ends active phase", {a[15:0], b[15:0]}, {16'd3, 16'd5});

        // R1 reset again mid-run
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(count_val == 0 && pwm_out == 0 && !stat_running && !stat_pol,
              "R1", "reset while running", {count_val, pwm_out}, 0);
        repeat (3) @(negedge clk);
        check(count_val == 0, "R2", "stopped after reset", count_val, 0);

        finish_run();
    end

endmodule